// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block schedules refresh for an asynchronous DRAM array that refreshes itself from an internal row counter when the column strobe is asserted before the row strobe. No row address is supplied. After a synchronous reset the block waits out a power-up pause. It then asks the access controller for a fixed number of warm-up refresh cycles. Only after those cycles are done does it declare the memory usable. From then on it raises a refresh request at a fixed interval. It keeps count of refreshes that the controller has postponed, so that no row loses its charge within the retention period.

At the default 100 MHz clock the values are as follows:
- The pause is 20,000 cycles, which is 200 µs.
- Eight warm-up refreshes are required.
- One refresh becomes due every 1560 cycles. This gives 1024 refreshes in less than 16 ms.
- Up to eight postponed refreshes can be owed at one time.

The controller generates the strobe waveforms. Each refresh takes a full random cycle, including row precharge.

The request side follows valid/ready rules:
- `refresh_req` acts as the valid signal. Once raised, it stays high until the owed work has been taken.
- `refresh_done` acts as the ready signal. It is a one-cycle pulse that the controller gives when a refresh cycle has finished.
- One completed refresh is counted only in a cycle where both signals are high.
- When `refresh_req` is low, `refresh_done` is ignored. The controller can hold off refreshes for as long as it needs. The postponed work piles up as the owed count.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its state. After that edge, `refresh_req`, `mem_ready` and `refresh_overrun` are all 0.
- R2: After `rst` is released, `refresh_req` stays low for the first PAUSE_CYCLES-1 rising edges. It goes high after edge number PAUSE_CYCLES.
- R3: During warm-up, `refresh_req` stays high and `mem_ready` stays low. `mem_ready` rises after the edge that takes warm-up handshake number INIT_REFRESHES, and not before.
- R4: A `refresh_done` pulse while `refresh_req` is low has no effect. It does not shorten the pause, it does not count as a warm-up refresh, and it does not cancel a refresh that becomes due later.
- R5: Once ready, the block adds one owed refresh after every INTERVAL_CYCLES edges. The first one is added at edge INTERVAL_CYCLES, counted from the edge that raised `mem_ready`.
- R6: After ready, `refresh_req` is high exactly when the owed count is nonzero. Each handshake lowers the count by one.
- R7: The owed count saturates at PEND_MAX. Once saturated, exactly PEND_MAX handshakes, with no new ticks arriving, bring `refresh_req` low.
- R8: `refresh_overrun` goes high after the edge where the owed count reaches PEND_MAX. It stays high until reset.
- R9: A handshake in the same cycle as an interval tick leaves the owed count unchanged.
- R10: A reset asserted while the block is running clears ready, the request and overrun. It also restarts the full pause.
- R11: Once `mem_ready` is high, it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| refresh_done | input | 1 | Controller finished one refresh cycle (ready side of the handshake) |
| refresh_req | output | 1 | One or more refreshes owed (valid side of the handshake) |
| mem_ready | output | 1 | Power-up sequence finished; normal accesses allowed |
| refresh_overrun | output | 1 | Sticky: owed count reached its limit |

## Verification
The hardest state to reach is the one where a handshake lands in the same cycle as an interval tick. This happens once the owed count is already nonzero, and it is where counting errors usually hide. The bench reaches it as follows. It first leaves one tick unserved. It then times each `refresh_done` pulse to arrive on the edge where an arithmetic model of the interval predicts the next tick. The request must then stay high indefinitely. A second hard state is saturation. The bench reaches it by withholding all handshakes for several intervals. It then counts exactly PEND_MAX handshakes until the request drops, while overrun stays set.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;
  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_WARM  = 2'd1,
    PH_RUN   = 2'd2
  } seq_phase_e;
endpackage

// File: rtl/refr_timer.sv
module refr_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [TW-1:0] last,
  output logic          expire
);
  logic [TW-1:0] cnt_q;

  assign expire = run && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst || !run || expire) cnt_q <= '0;
    else                       cnt_q <= cnt_q + TW'(1);
  end

  assert_timer_bound_R5: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q <= last));
endmodule

// File: rtl/refr_pending.sv
module refr_pending #(
  parameter int PEND_MAX = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic take,
  output logic owed,
  output logic overrun
);
  localparam int PW = $clog2(PEND_MAX + 1);
  localparam logic [PW-1:0] MAXV = PW'(PEND_MAX);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          dec;

  assign dec  = take && (cnt_q != '0);
  assign owed = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (tick && !dec)      cnt_d = (cnt_q == MAXV) ? cnt_q : cnt_q + PW'(1);
    else if (!tick && dec) cnt_d = cnt_q - PW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      overrun <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      overrun <= overrun | (cnt_d == MAXV);
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= MAXV);
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  assert_tick_take_balance_R9: assert property (@(posedge clk) disable iff (rst)
    (tick && take && owed) |=> $stable(cnt_q));
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int PAUSE_CYCLES   = 20000,
  parameter int INIT_REFRESHES = 8,
  parameter int INTERVAL_CYCLES = 1560,
  parameter int PEND_MAX       = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic refresh_done,
  output logic refresh_req,
  output logic mem_ready,
  output logic refresh_overrun
);
  import dram_refresh_pkg::*;

  localparam int TMAX = (PAUSE_CYCLES > INTERVAL_CYCLES) ? PAUSE_CYCLES : INTERVAL_CYCLES;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int IW   = $clog2(INIT_REFRESHES + 1);
  localparam logic [TW-1:0] PAUSE_LAST = TW'(PAUSE_CYCLES - 1);
  localparam logic [TW-1:0] IVL_LAST   = TW'(INTERVAL_CYCLES - 1);
  localparam logic [IW-1:0] WARM_LAST  = IW'(INIT_REFRESHES - 1);

  seq_phase_e    phase_q;
  logic [IW-1:0] warm_q;
  logic          tmr_run, tmr_exp, hs, owed;

  assign tmr_run     = (phase_q == PH_PAUSE) || (phase_q == PH_RUN);
  assign hs          = refresh_req && refresh_done;
  assign mem_ready   = (phase_q == PH_RUN);
  assign refresh_req = (phase_q == PH_WARM) || ((phase_q == PH_RUN) && owed);

  refr_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (tmr_run),
    .last   ((phase_q == PH_PAUSE) ? PAUSE_LAST : IVL_LAST),
    .expire (tmr_exp)
  );

  refr_pending #(.PEND_MAX(PEND_MAX)) u_pending (
    .clk     (clk),
    .rst     (rst),
    .tick    (tmr_exp && (phase_q == PH_RUN)),
    .take    (hs && (phase_q == PH_RUN)),
    .owed    (owed),
    .overrun (refresh_overrun)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_PAUSE;
      warm_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_PAUSE: if (tmr_exp) phase_q <= PH_WARM;
        PH_WARM: if (hs) begin
          if (warm_q == WARM_LAST) phase_q <= PH_RUN;
          else                     warm_q  <= warm_q + IW'(1);
        end
        default: phase_q <= PH_RUN;
      endcase
    end
  end

  assert_quiet_pause_R2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_PAUSE) |-> !refresh_req);
  assert_ready_after_warm_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_ready) |-> $past(refresh_req && refresh_done));
  assert_ready_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    mem_ready |=> mem_ready);
endmodule

// File: tb/dram_refresh_seq_bench.sv
module dram_refresh_seq_bench;
  localparam int P   = 12;
  localparam int NI  = 8;
  localparam int INT = 10;
  localparam int M   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic done = 1'b0;
  logic req, rdy, ovr;
  int   checks = 0;
  int   fails  = 0;
  bit   finished = 1'b0;
  int   t = 0, mp = 0;
  bit   movr = 1'b0;

  always #10 clk = ~clk;

  dram_refresh_seq #(.PAUSE_CYCLES(P), .INIT_REFRESHES(NI),
                     .INTERVAL_CYCLES(INT), .PEND_MAX(M)) u_dram_refresh_seq (
    .clk(clk), .rst(rst), .refresh_done(done),
    .refresh_req(req), .mem_ready(rdy), .refresh_overrun(ovr));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic pause_sweep(string tag);
    rst = 1'b0;
    for (int k = 1; k <= P; k++) begin
      done = (k < P);
      step();
      chk({tag, " req"}, req, (k == P));
      chk({tag, " rdy"}, rdy, 0);
    end
  endtask

  task automatic warm_up();
    for (int i = 1; i <= NI; i++) begin
      done = 1'b0;
      step();
      chk("R3 req held", req, 1);
      chk("R3 not ready", rdy, 0);
      done = 1'b1;
      step();
      chk("R3 ready edge", rdy, (i == NI));
    end
    done = 1'b0;
    t = 0; mp = 0; movr = 1'b0;
  endtask

  // mode 0: always done, 1: never, 2: every third cycle, 3: on tick edges
  task automatic run_mode(string tag, int mode, int cycles);
    for (int c = 0; c < cycles; c++) begin
      bit d, hs, tk;
      case (mode)
        0: d = 1'b1;
        1: d = 1'b0;
        2: d = (c % 3 == 0);
        default: d = ((t + 1) % INT == 0);
      endcase
      done = d;
      hs = d && (mp != 0);
      step();
      t++;
      tk = (t % INT == 0);
      if (tk && !hs) mp = (mp < M) ? mp + 1 : mp;
      else if (hs && !tk) mp--;
      if (mp == M) movr = 1'b1;
      chk({tag, " req"}, req, (mp != 0));
      chk({tag, " R8 overrun"}, ovr, movr);
      chk({tag, " R11 ready"}, rdy, 1);
    end
    done = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    done = 1'b1;
    repeat (3) step();
    chk("R1 req", req, 0);
    chk("R1 rdy", rdy, 0);
    chk("R1 overrun", ovr, 0);
    pause_sweep("R2 R4 pause");
    warm_up();
    run_mode("R5 first tick", 1, INT);
    run_mode("R9 tick with take", 3, 3 * INT);
    run_mode("R4 R6 serve", 0, 3 * INT);
    run_mode("R6 sparse", 2, 3 * INT);
    run_mode("R7 saturate", 1, (M + 2) * INT);
    run_mode("R7 drain", 0, 2 * INT);
    rst = 1'b1;
    step();
    chk("R10 req", req, 0);
    chk("R10 rdy", rdy, 0);
    chk("R10 overrun", ovr, 0);
    pause_sweep("R10 R2 restart");
    warm_up();
    run_mode("R10 R5 rerun", 2, 2 * INT);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule